// File: doc/BRIEF.md
# Paged User Address Translator

This block turns a 14-bit virtual address into a 16-bit physical address. The upper three virtual bits pick one of eight mapping entries. Each entry holds a 5-bit physical block number and a protection flag. The chosen block number is placed above the low eleven virtual bits, so a program sees eight contiguous 2048-word blocks placed anywhere among 32 physical blocks. The translation path is purely combinational, so an access takes no extra cycle. Only the map storage is clocked.

The eight entries sit in two 24-bit map registers of four entries each. Software reloads a register in two steps. First it issues the arm command for that register, which zeroes the register at once. The next load strobe then writes a full 24-bit word into it. When the protection flag is set, the entry's block number decides which trap applies. With a zero block number the entry counts as unassigned, and any access to it traps with vector 41 octal. With a nonzero block number the entry is read-only, and only writes trap, with vector 43 octal. While either trap is raised, the strobe toward memory is held low.

Top module: `paged_xlate_top`

## Requirements
- R1: `paddr` equals the selected entry's 5-bit block number followed by `vaddr[10:0]`, and `vaddr[13:11]` selects the entry. `paddr` reflects `vaddr` in the same cycle, with no register on the path.
- R2: Entries 0 to 3 live in map register 0 and entries 4 to 7 in map register 1. Within a register, entry slot s occupies bits [23-6s : 18-6s]. The top bit of each field is the protection flag and the lower five bits are the block number.
- R3: One clock after `arm_lo` is asserted, map register 0 reads as all zeros. One clock after `arm_hi` is asserted, map register 1 reads as all zeros.
- R4: After an arm command, the first `load_stb` writes `load_word` into the armed register and disarms. A further `load_stb` with no new arm changes nothing.
- R5: Out of reset, or after a completed load, a `load_stb` with no pending arm command leaves both map registers unchanged.
- R6: An access with `acc_wr`=1 to an entry with protection flag 1 and a nonzero block number raises `trap_wprot`, and `trap_vec` reads 6'o43. A read of such an entry does not trap.
- R7: Any access (read or write) to an entry with protection flag 1 and block number 0 raises `trap_unasg`, and `trap_vec` reads 6'o41. This trap excludes `trap_wprot`.
- R8: `mem_req` equals `acc_req` unless a trap is raised, in which case it is 0. With `acc_req`=0, no trap is raised and `trap_vec` is 0.
- R9: After reset, both map registers are zero and no arm is pending. Every address then maps to block 0 with no trap.
- R10: If `arm_lo` and `arm_hi` are asserted in the same cycle, only register 0 is cleared and armed. Register 1 keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_lo | input | 1 | Clear map register 0 and arm it for loading |
| arm_hi | input | 1 | Clear map register 1 and arm it for loading |
| load_stb | input | 1 | Load strobe for the armed register |
| load_word | input | 24 | Word written on a load |
| acc_req | input | 1 | Memory access request |
| acc_wr | input | 1 | 1 for write access, 0 for read |
| vaddr | input | 14 | Virtual address |
| paddr | output | 16 | Translated physical address |
| mem_req | output | 1 | Access strobe toward memory, suppressed on trap |
| trap_unasg | output | 1 | Unassigned-block trap |
| trap_wprot | output | 1 | Write-protect trap |
| trap_vec | output | 6 | Trap vector code, 0 when no trap |

## Verification
The hardest states to reach are the armed window and the ignored strobes, because the arm state is never visible at the ports. The bench makes it visible through translation. Right after an arm it probes entries of the cleared register and expects block 0 with no trap. It then sends extra load strobes carrying all-ones data and confirms the decoded entries have not moved. A simultaneous arm of both registers is followed by a probe of an entry in register 1, which shows that register 1 survived.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    parameter int VA_W     = 14;
    parameter int IDX_W    = 3;
    parameter int BLK_W    = 5;
    parameter int OFS_W    = VA_W - IDX_W;
    parameter int PA_W     = BLK_W + OFS_W;
    parameter int ENTRIES  = 1 << IDX_W;
    parameter int REG_W    = 24;
    parameter int ENT_W    = BLK_W + 1;
    parameter int PER_REG  = REG_W / ENT_W;
    parameter int NREG     = ENTRIES / PER_REG;
    parameter int VEC_W    = 6;

    parameter logic [VEC_W-1:0] VEC_NONE  = 6'o00;
    parameter logic [VEC_W-1:0] VEC_UNASG = 6'o41;
    parameter logic [VEC_W-1:0] VEC_WPROT = 6'o43;

    typedef struct packed {
        logic             prot;
        logic [BLK_W-1:0] blk;
    } map_ent_t;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_LO   = 2'd1,
        LD_HI   = 2'd2
    } ld_state_t;

    function automatic logic is_unassigned(map_ent_t e);
        return e.prot && (e.blk == '0);
    endfunction

    function automatic logic is_readonly(map_ent_t e);
        return e.prot && (e.blk != '0);
    endfunction
endpackage

// File: rtl/xlate_map_store.sv
module xlate_map_store
    import xlate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  arm_lo,
    input  logic                  arm_hi,
    input  logic                  load_stb,
    input  logic [REG_W-1:0]      load_word,
    output logic [NREG*REG_W-1:0] map_flat
);
    logic [REG_W-1:0] map_q [NREG];
    ld_state_t        st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LD_IDLE;
            for (int r = 0; r < NREG; r++) map_q[r] <= '0;
        end else if (arm_lo) begin
            map_q[0] <= '0;
            st_q     <= LD_LO;
        end else if (arm_hi) begin
            map_q[1] <= '0;
            st_q     <= LD_HI;
        end else if (load_stb && st_q != LD_IDLE) begin
            if (st_q == LD_LO) map_q[0] <= load_word;
            else               map_q[1] <= load_word;
            st_q <= LD_IDLE;
        end
    end

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_flat
            assign map_flat[r*REG_W +: REG_W] = map_q[r];
        end
    endgenerate

    // R3: an arm command empties its register on the next clock
    assert_clear_lo_R3: assert property (@(posedge clk) disable iff (rst)
        arm_lo |=> (map_q[0] == '0));
    // R10: a simultaneous arm leaves register 1 alone
    assert_arm_prio_R10: assert property (@(posedge clk) disable iff (rst)
        (arm_lo && arm_hi) |=> $stable(map_q[1]));
    // R5: without a pending arm, a load strobe changes nothing
    assert_noarm_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == LD_IDLE && !arm_lo && !arm_hi) |=> ($stable(map_q[0]) && $stable(map_q[1])));
endmodule

// File: rtl/xlate_lookup.sv
module xlate_lookup
    import xlate_pkg::*;
(
    input  logic [NREG*REG_W-1:0] map_flat,
    input  logic [VA_W-1:0]       vaddr,
    output map_ent_t              ent,
    output logic [PA_W-1:0]       paddr
);
    map_ent_t table_w [ENTRIES];

    generate
        for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
            localparam int RIDX = k / PER_REG;
            localparam int SLOT = k % PER_REG;
            localparam int TOP  = RIDX*REG_W + REG_W - 1 - SLOT*ENT_W;
            assign table_w[k] = map_ent_t'(map_flat[TOP -: ENT_W]);
        end
    endgenerate

    logic [IDX_W-1:0] idx;
    assign idx   = vaddr[VA_W-1 -: IDX_W];
    assign ent   = table_w[idx];
    assign paddr = {ent.blk, vaddr[OFS_W-1:0]};
endmodule

// File: rtl/xlate_trap_check.sv
module xlate_trap_check
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  map_ent_t         ent,
    input  logic             acc_req,
    input  logic             acc_wr,
    output logic             trap_unasg,
    output logic             trap_wprot,
    output logic [VEC_W-1:0] trap_vec,
    output logic             mem_req
);
    always_comb begin
        trap_unasg = acc_req && is_unassigned(ent);
        trap_wprot = acc_req && acc_wr && !trap_unasg && is_readonly(ent);
        if (trap_unasg)      trap_vec = VEC_UNASG;
        else if (trap_wprot) trap_vec = VEC_WPROT;
        else                 trap_vec = VEC_NONE;
        mem_req = acc_req && !trap_unasg && !trap_wprot;
    end

    // R7: at most one trap at a time
    assert_one_trap_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap_unasg, trap_wprot}));
    // R8: a trap blocks the memory strobe
    assert_trap_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (trap_unasg || trap_wprot) |-> !mem_req);
    // R6: the write-protect trap only accompanies writes
    assert_wprot_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        trap_wprot |-> (acc_wr && acc_req));
endmodule

// File: rtl/paged_xlate_top.sv
module paged_xlate_top
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_lo,
    input  logic             arm_hi,
    input  logic             load_stb,
    input  logic [23:0]      load_word,
    input  logic             acc_req,
    input  logic             acc_wr,
    input  logic [13:0]      vaddr,
    output logic [15:0]      paddr,
    output logic             mem_req,
    output logic             trap_unasg,
    output logic             trap_wprot,
    output logic [5:0]       trap_vec
);
    logic [NREG*REG_W-1:0] map_flat;
    map_ent_t              ent;

    xlate_map_store u_store (
        .clk(clk), .rst(rst), .arm_lo(arm_lo), .arm_hi(arm_hi),
        .load_stb(load_stb), .load_word(load_word), .map_flat(map_flat)
    );

    xlate_lookup u_lookup (
        .map_flat(map_flat), .vaddr(vaddr), .ent(ent), .paddr(paddr)
    );

    xlate_trap_check u_trap (
        .clk(clk), .rst(rst), .ent(ent), .acc_req(acc_req), .acc_wr(acc_wr),
        .trap_unasg(trap_unasg), .trap_wprot(trap_wprot),
        .trap_vec(trap_vec), .mem_req(mem_req)
    );

    // R1: the offset bits pass straight through
    assert_offset_R1: assert property (@(posedge clk) disable iff (rst)
        paddr[OFS_W-1:0] == vaddr[OFS_W-1:0]);
    // R8: an idle port raises no trap
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !acc_req |-> (trap_vec == VEC_NONE && !mem_req));
endmodule

// File: tb/paged_xlate_top_test.sv
module paged_xlate_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm_lo = 1'b0, arm_hi = 1'b0, load_stb = 1'b0;
    logic [23:0] load_word = '0;
    logic        acc_req = 1'b0, acc_wr = 1'b0;
    logic [13:0] vaddr = '0;
    logic [15:0] paddr;
    logic        mem_req, trap_unasg, trap_wprot;
    logic [5:0]  trap_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    paged_xlate_top uut (
        .clk(clk), .rst(rst), .arm_lo(arm_lo), .arm_hi(arm_hi),
        .load_stb(load_stb), .load_word(load_word), .acc_req(acc_req),
        .acc_wr(acc_wr), .vaddr(vaddr), .paddr(paddr), .mem_req(mem_req),
        .trap_unasg(trap_unasg), .trap_wprot(trap_wprot), .trap_vec(trap_vec)
    );

    // per R2: field = {prot, blk}, slot 0 at the top of the word
    localparam logic [23:0] WORD_LO = {6'h05, 6'h20, 6'h29, 6'h1F};
    localparam logic [23:0] WORD_HI = {6'h01, 6'h31, 6'h00, 6'h20};

    // {vaddr, wr, paddr, vec, mem}
    localparam int NV = 10;
    localparam logic [37:0] VECS [NV] = '{
        {14'h0123, 1'b0, 16'h2923, 6'o00, 1'b1},
        {14'h0FFF, 1'b0, 16'h07FF, 6'o41, 1'b0},
        {14'h1000, 1'b0, 16'h4800, 6'o00, 1'b1},
        {14'h1001, 1'b1, 16'h4801, 6'o43, 1'b0},
        {14'h1C00, 1'b1, 16'hFC00, 6'o00, 1'b1},
        {14'h2055, 1'b0, 16'h0855, 6'o00, 1'b1},
        {14'h2810, 1'b1, 16'h8810, 6'o43, 1'b0},
        {14'h33FF, 1'b1, 16'h03FF, 6'o00, 1'b1},
        {14'h3FFF, 1'b1, 16'h07FF, 6'o41, 1'b0},
        {14'h3800, 1'b0, 16'h0000, 6'o41, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic probe(input logic [13:0] va, input logic wr, input logic req,
                         input logic [15:0] ep, input logic [5:0] ev, input logic em,
                         input string tag);
        @(negedge clk);
        vaddr = va; acc_wr = wr; acc_req = req;
        #2;
        check(paddr == ep, tag, {8'h0, paddr}, {8'h0, ep});
        check(trap_vec == ev && trap_unasg == (ev == 6'o41) && trap_wprot == (ev == 6'o43),
              tag, {18'h0, trap_vec}, {18'h0, ev});
        check(mem_req == em, tag, {23'h0, mem_req}, {23'h0, em});
    endtask

    task automatic pulse_arm(input bit lo, input bit hi);
        @(negedge clk); arm_lo = lo; arm_hi = hi;
        @(negedge clk); arm_lo = 1'b0; arm_hi = 1'b0;
    endtask

    task automatic pulse_load(input logic [23:0] w);
        @(negedge clk); load_stb = 1'b1; load_word = w;
        @(negedge clk); load_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R9: after reset every entry maps to block 0, no trap
        probe(14'h3FFF, 1'b1, 1'b1, 16'h07FF, 6'o00, 1'b1, "R9 reset map");
        probe(14'h1234, 1'b0, 1'b1, 16'h0234, 6'o00, 1'b1, "R9 reset map");
        // R5: load strobe out of reset is ignored
        pulse_load(24'hFFFFFF);
        probe(14'h0000, 1'b1, 1'b1, 16'h0000, 6'o00, 1'b1, "R5 unarmed load");

        pulse_arm(1'b1, 1'b0); pulse_load(WORD_LO);
        pulse_arm(1'b0, 1'b1); pulse_load(WORD_HI);

        // R1 R2 R6 R7 R8: vector table
        for (int i = 0; i < NV; i++) begin
            probe(VECS[i][37:24], VECS[i][23], 1'b1, VECS[i][22:7], VECS[i][6:1], VECS[i][0],
                  "R1/R2/R6/R7 table");
        end

        // R8: no request means no trap and no strobe, even on an unassigned entry
        probe(14'h3FFF, 1'b1, 1'b0, 16'h07FF, 6'o00, 1'b0, "R8 idle");

        // R5: strobe after completed load is ignored
        pulse_load(24'hFFFFFF);
        probe(14'h0123, 1'b0, 1'b1, 16'h2923, 6'o00, 1'b1, "R5 post-load strobe");
        probe(14'h2810, 1'b0, 1'b1, 16'h8810, 6'o00, 1'b1, "R6 read of read-only");

        // R3: arm clears register 0 immediately
        pulse_arm(1'b1, 1'b0);
        probe(14'h1001, 1'b1, 1'b1, 16'h0001, 6'o00, 1'b1, "R3 cleared lo");
        probe(14'h0FFF, 1'b0, 1'b1, 16'h07FF, 6'o00, 1'b1, "R3 cleared lo");
        // R4: first load writes, second is ignored
        pulse_load(WORD_LO);
        probe(14'h0123, 1'b0, 1'b1, 16'h2923, 6'o00, 1'b1, "R4 armed load");
        pulse_load(24'hFFFFFF);
        probe(14'h1001, 1'b1, 1'b1, 16'h4801, 6'o43, 1'b0, "R4 second load ignored");

        // R3: arm of register 1
        pulse_arm(1'b0, 1'b1);
        probe(14'h2810, 1'b1, 1'b1, 16'h0010, 6'o00, 1'b1, "R3 cleared hi");
        pulse_load(WORD_HI);
        probe(14'h2055, 1'b0, 1'b1, 16'h0855, 6'o00, 1'b1, "R4 hi load");

        // R10: simultaneous arm targets register 0 only
        pulse_arm(1'b1, 1'b1);
        probe(14'h2810, 1'b1, 1'b1, 16'h8810, 6'o43, 1'b0, "R10 hi kept");
        probe(14'h0123, 1'b0, 1'b1, 16'h0123, 6'o00, 1'b1, "R10 lo cleared");
        pulse_load(WORD_LO);
        probe(14'h0123, 1'b0, 1'b1, 16'h2923, 6'o00, 1'b1, "R10 load to lo");
        probe(14'h3FFF, 1'b0, 1'b1, 16'h07FF, 6'o41, 1'b0, "R10 hi still intact");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule